// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of one SDRAM burst. A column command sets the start strobe together with an 8-bit start column, a 4-bit mode word and a read or write flag. From the next cycle the block presents one column address per clock. `valid_o` marks the cycles that carry a beat, and `last_o` marks the final beat of a finite burst. The command decoder, the data path and the read latency pipeline sit outside this block. They use `col_o` to index the column for each data beat.

Bursts of 1, 2, 4 or 8 beats stay inside the block of columns that is aligned to the burst length. The low bits either count up and wrap (sequential) or are the start bits XOR the beat number (interleaved). A full-page sequential burst walks all 256 columns and keeps going until a stop arrives. When the single-write option is set, a write is cut to one beat while reads keep the programmed length. A stop (burst terminate or precharge) or a new column command ends the running burst. When the clock enable is low, the whole block is frozen.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `valid_o` and `last_o` are low until a legal start is accepted.
- R2: The mode word uses bit 3 as the order select (0 sequential, 1 interleaved) and bits 2:0 as the length code: 000, 001, 010 and 011 give 1, 2, 4 and 8 beats. A start accepted at one edge shows beat 0 after that edge and one beat per enabled edge after it. `last_o` is high on the final beat only, and `valid_o` falls after the final beat unless a new start is accepted.
- R3: In sequential order, beat i carries (start + i) modulo the burst length in its low bits. For example, 8 beats from column 5 give 5,6,7,0,1,2,3,4.
- R4: In interleaved order, beat i carries the start low bits XOR i. For example, 8 beats from column 5 give 5,4,7,6,1,0,3,2.
- R5: Column bits above the burst-aligned block keep their start value for the whole burst.
- R6: Length code 111 with sequential order runs a full page. Beat i is (start + i) modulo 256, the walk repeats without end, and `last_o` stays low.
- R7: Length codes 100, 101 and 110, and code 111 with interleaved order, are refused. No beat appears, and a running burst is ended.
- R8: When `wr_single_i` is high, a write start gives exactly one beat at the start column with `last_o` high. A read start keeps the programmed length.
- R9: `stop_i` sampled high with `cke_i` high and no start ends the burst. `valid_o` is low after that edge.
- R10: A legal start during a running burst abandons the old burst. The new sequence begins at its own start column after that edge.
- R11: While `cke_i` is low at an edge, the outputs and beat count keep their values, and `start_i` and `stop_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable; low freezes the block |
| start_i | input | 1 | Column command strobe |
| is_write_i | input | 1 | The column command is a write |
| wr_single_i | input | 1 | Single-beat write option |
| mode_i | input | 4 | [3] order select, [2:0] length code |
| start_col_i | input | 8 | Start column |
| stop_i | input | 1 | Burst terminate or precharge |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | A beat is present |
| last_o | output | 1 | Final beat of a finite burst |

## Verification
A wrong beat counter or a wrong latched start shows at `col_o` on the first beat after the fault. A wrong ordering, wrap or high-bit hold shows as one out-of-sequence column on the beat where the wrap or the XOR pattern first differs. A wrong length or end detection shows within one cycle of the expected final beat, either as a missing `last_o`, a missing beat or a beat too many. Stall faults show as a column that changes, or a beat that is skipped, in the cycle after `cke_i` falls or rises.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int unsigned MODE_W   = 4;
  localparam int unsigned LEN_W    = 3;
  localparam int unsigned ORDER_BIT = 3;

  typedef enum logic [LEN_W-1:0] {
    BL_ONE   = 3'b000,
    BL_TWO   = 3'b001,
    BL_FOUR  = 3'b010,
    BL_EIGHT = 3'b011,
    BL_PAGE  = 3'b111
  } bl_code_e;
endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              is_write_i,
  input  logic              wr_single_i,
  output logic              legal_o,
  output logic              full_o,
  output logic              ilv_o,
  output logic [COL_W-1:0]  mask_o
);
  logic [LEN_W-1:0] code;
  logic [LEN_W-1:0] shift;

  assign code  = mode_i[LEN_W-1:0];
  assign ilv_o = mode_i[ORDER_BIT];

  always_comb begin
    legal_o = 1'b0;
    full_o  = 1'b0;
    shift   = '0;
    if (is_write_i && wr_single_i) begin
      legal_o = 1'b1;
    end else begin
      case (code)
        BL_ONE, BL_TWO, BL_FOUR, BL_EIGHT: begin
          legal_o = 1'b1;
          shift   = code;
        end
        BL_PAGE: begin
          legal_o = !ilv_o;
          full_o  = 1'b1;
        end
        default: legal_o = 1'b0;
      endcase
    end
  end

  // low-bit mask of the burst block; equals beat count minus one
  assign mask_o = full_o ? {COL_W{1'b1}}
                         : COL_W'((COL_W'(1) << shift) - COL_W'(1));
endmodule

// File: rtl/colgen_addr_gen.sv
module colgen_addr_gen #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low;

  assign low = ilv_i ? (base_i ^ idx_i) : COL_W'(base_i + idx_i);

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? low[b] : base_i[b];
  end
endmodule

// File: rtl/colgen_beat_seq.sv
module colgen_beat_seq #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             legal_i,
  input  logic             full_i,
  input  logic             ilv_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic [COL_W-1:0] start_col_i,
  output logic             active_o,
  output logic             last_o,
  output logic             ilv_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] idx_o,
  output logic [COL_W-1:0] mask_o
);
  logic             active_q, full_q, ilv_q;
  logic [COL_W-1:0] base_q, idx_q, mask_q;
  logic             at_last;

  assign at_last = active_q && !full_q && (idx_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      base_q   <= '0;
      idx_q    <= '0;
      mask_q   <= '0;
    end else if (cke_i) begin
      if (start_i && legal_i) begin
        active_q <= 1'b1;
        full_q   <= full_i;
        ilv_q    <= ilv_i;
        base_q   <= start_col_i;
        idx_q    <= '0;
        mask_q   <= mask_i;
      end else if (start_i || stop_i || at_last) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        idx_q <= COL_W'(idx_q + COL_W'(1));
      end
    end
  end

  assign active_o = active_q;
  assign last_o   = at_last;
  assign ilv_o    = ilv_q;
  assign base_o   = base_q;
  assign idx_o    = idx_q;
  assign mask_o   = mask_q;

  a_r11_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> $stable(active_q) && $stable(idx_q) && $stable(base_q));
  a_r9_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && stop_i && !start_i |=> !active_q);
  a_r2_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && at_last && !start_i |=> !active_q);
  a_r7_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && start_i && !legal_i |=> !active_q);
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              start_i,
  input  logic              is_write_i,
  input  logic              wr_single_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o
);
  logic             dec_legal, dec_full, dec_ilv;
  logic [COL_W-1:0] dec_mask;
  logic             seq_ilv;
  logic [COL_W-1:0] seq_base, seq_idx, seq_mask;

  colgen_mode_dec #(.COL_W(COL_W)) u_dec (
    .mode_i      (mode_i),
    .is_write_i  (is_write_i),
    .wr_single_i (wr_single_i),
    .legal_o     (dec_legal),
    .full_o      (dec_full),
    .ilv_o       (dec_ilv),
    .mask_o      (dec_mask)
  );

  colgen_beat_seq #(.COL_W(COL_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cke_i       (cke_i),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .legal_i     (dec_legal),
    .full_i      (dec_full),
    .ilv_i       (dec_ilv),
    .mask_i      (dec_mask),
    .start_col_i (start_col_i),
    .active_o    (valid_o),
    .last_o      (last_o),
    .ilv_o       (seq_ilv),
    .base_o      (seq_base),
    .idx_o       (seq_idx),
    .mask_o      (seq_mask)
  );

  colgen_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_i (seq_base),
    .idx_i  (seq_idx),
    .mask_i (seq_mask),
    .ilv_i  (seq_ilv),
    .col_o  (col_o)
  );

  a_r10_first_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && start_i && dec_legal |=> valid_o && (col_o == $past(start_col_i)));
  a_r5_high_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o && cke_i && !start_i && !stop_i
      |=> ((col_o ^ $past(col_o)) & ~seq_mask) == '0);
  a_r1_last_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
endmodule

// File: tb/sdram_burst_colgen_tb_top.sv
module sdram_burst_colgen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cke_i = 1'b1;
  logic       start_i = 1'b0;
  logic       is_write_i = 1'b0;
  logic       wr_single_i = 1'b0;
  logic [3:0] mode_i = 4'h0;
  logic [7:0] start_col_i = 8'h00;
  logic       stop_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o, last_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic prev_cke = 1'b1;
  logic [8:0] exp_q[$];
  string cur_req = "R2";

  always #2.5 clk_i = ~clk_i;

  sdram_burst_colgen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i), .start_i(start_i),
    .is_write_i(is_write_i), .wr_single_i(wr_single_i), .mode_i(mode_i),
    .start_col_i(start_col_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_col(input logic [7:0] s, input int i,
                                         input logic [3:0] md, input bit one);
    int n;
    logic [7:0] m, low;
    if (one) n = 0;
    else if (md[2:0] == 3'b111) n = 8;
    else n = int'(md[2:0]);
    m   = (n == 8) ? 8'hFF : 8'((1 << n) - 1);
    low = md[3] ? (s ^ 8'(i)) : 8'(int'(s) + i);
    return (s & ~m) | (low & m);
  endfunction

  function automatic int burst_len(input logic [3:0] md, input bit one);
    if (one) return 1;
    if (md[2:0] == 3'b111) return 0;
    return 1 << md[2:0];
  endfunction

  // scoreboard monitor
  always @(posedge clk_i) prev_cke <= cke_i;
  always @(negedge clk_i) begin
    if (rst_ni && prev_cke && valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected beat col", int'(col_o), 0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk(col_o == e[7:0], cur_req, "beat col", int'(col_o), int'(e[7:0]));
        chk(last_o == e[8], cur_req, "beat last", int'(last_o), int'(e[8]));
      end
    end
  end

  task automatic push_beats(input logic [7:0] s, input logic [3:0] md,
                            input bit one, input int n);
    int len;
    len = burst_len(md, one);
    for (int i = 0; i < n; i++)
      exp_q.push_back({(len != 0) && (i == len - 1), exp_col(s, i, md, one)});
  endtask

  task automatic drain_check(input string req);
    repeat (2) @(negedge clk_i);
    chk(exp_q.size() == 0, req, "missing beats", exp_q.size(), 0);
    chk(valid_o == 1'b0, req, "valid after end", int'(valid_o), 0);
    exp_q.delete();
  endtask

  // keep > 0 stops after keep beats; keep == 0 runs the whole burst
  task automatic run_burst(input logic [7:0] s, input logic [3:0] md,
                           input bit wr, input bit single, input int keep,
                           input string req);
    int len, n;
    bit one;
    cur_req = req;
    one = wr && single;
    len = burst_len(md, one);
    n = (keep > 0 && (len == 0 || keep < len)) ? keep : len;
    push_beats(s, md, one, n);
    @(negedge clk_i);
    start_i = 1'b1; start_col_i = s; mode_i = md;
    is_write_i = wr; wr_single_i = single;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (n - 1) @(negedge clk_i);
    if (len == 0 || n < len) begin
      stop_i = 1'b1;
      @(negedge clk_i);
      stop_i = 1'b0;
    end
    drain_check(req);
  endtask

  task automatic refused(input logic [3:0] md, input string req);
    cur_req = req;
    @(negedge clk_i);
    start_i = 1'b1; start_col_i = 8'h33; mode_i = md;
    is_write_i = 1'b0; wr_single_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(valid_o == 1'b0, req, "refused code gave beat", int'(valid_o), 0);
    @(negedge clk_i);
    chk(valid_o == 1'b0, req, "refused code gave beat", int'(valid_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R1", "valid in reset", int'(valid_o), 0);
    chk(last_o == 1'b0, "R1", "last in reset", int'(last_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(valid_o == 1'b0, "R1", "valid after reset", int'(valid_o), 0);

    // R2 lengths, R3 sequential wrap, R5 high bits fixed
    run_burst(8'hA7, 4'b0000, 1'b0, 1'b0, 0, "R2");
    run_burst(8'hA7, 4'b0001, 1'b0, 1'b0, 0, "R2");
    run_burst(8'hA6, 4'b0010, 1'b0, 1'b0, 0, "R3");
    run_burst(8'h05, 4'b0011, 1'b0, 1'b0, 0, "R3");
    run_burst(8'hED, 4'b0011, 1'b0, 1'b0, 0, "R5");
    // R4 interleaved
    run_burst(8'h05, 4'b1011, 1'b0, 1'b0, 0, "R4");
    run_burst(8'h9B, 4'b1010, 1'b0, 1'b0, 0, "R4");
    run_burst(8'h61, 4'b1001, 1'b0, 1'b0, 0, "R4");
    // R6 full page, wraps past 0xFF and past its own start
    run_burst(8'hFA, 4'b0111, 1'b0, 1'b0, 300, "R6");
    // R7 reserved codes
    refused(4'b0100, "R7");
    refused(4'b0101, "R7");
    refused(4'b0110, "R7");
    refused(4'b1111, "R7");
    // R8 single write override
    run_burst(8'h2D, 4'b0011, 1'b1, 1'b1, 0, "R8");
    run_burst(8'h2D, 4'b0111, 1'b1, 1'b1, 0, "R8");
    run_burst(8'h2D, 4'b0011, 1'b0, 1'b1, 0, "R8");
    run_burst(8'h2D, 4'b0010, 1'b1, 1'b0, 0, "R8");
    // R9 stop mid burst
    run_burst(8'h40, 4'b0011, 1'b0, 1'b0, 3, "R9");
    run_burst(8'h47, 4'b1011, 1'b1, 1'b0, 1, "R9");

    // R10 restart during burst
    cur_req = "R10";
    push_beats(8'h05, 4'b0011, 1'b0, 3);
    push_beats(8'h42, 4'b1010, 1'b0, 4);
    @(negedge clk_i);
    start_i = 1'b1; start_col_i = 8'h05; mode_i = 4'b0011; is_write_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    start_i = 1'b1; start_col_i = 8'h42; mode_i = 4'b1010;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    drain_check("R10");

    // R11 stall: hold, start and stop ignored
    cur_req = "R11";
    push_beats(8'h13, 4'b0011, 1'b0, 8);
    @(negedge clk_i);
    start_i = 1'b1; start_col_i = 8'h13; mode_i = 4'b0011;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    cke_i = 1'b0; start_i = 1'b1; start_col_i = 8'hC0; stop_i = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk_i);
      chk(valid_o == 1'b1, "R11", "valid during stall", int'(valid_o), 1);
      chk(col_o == 8'h14, "R11", "col during stall", int'(col_o), 'h14);
    end
    cke_i = 1'b1; start_i = 1'b0; stop_i = 1'b0;
    repeat (6) @(negedge clk_i);
    drain_check("R11");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule